// File: doc/BRIEF.md
# SPI Radio Command Sequencer

This block sits between the requesters of a packet radio controller and a byte-wide SPI shifter. Each accepted request becomes one framed SPI transaction. The block builds the leading header byte and decides how many bytes follow it. It drives the active-low chip select and hands each byte to the shifter. It also sorts every byte the radio returns into one of three kinds: a status byte, read data, or a byte it drops.

Five request kinds are supported: configuration register write, configuration register read, single-byte command strobe, transmit-FIFO burst load and receive-FIFO burst read. Several requesters (by default a transmit side and a receive side) share the radio through a ready/start handshake. A round-robin arbiter chooses between them. Once a transaction starts, it runs to its end before another is granted. Write payload is pulled from the owner's data stream with a pop strobe. Read data comes back with a valid strobe and the owner's index.

Top module: `radio_spi_sequencer`

## Requirements
- R1: The header byte has bit 7 = 0, bit 6 = 1 for the two read kinds (register read, receive-FIFO read) and 0 otherwise, and bits 5:0 = the requested address. Request kind codes are: 0 register write, 1 register read, 2 strobe, 3 transmit-FIFO load, 4 receive-FIFO read.
- R2: A register write sends the header and then exactly REG_BYTES (default 2) bytes taken from the owner's write stream. Bytes returned during those payload bytes never appear on the read-data output.
- R3: The byte returned while the header shifts is presented as a status byte (status_valid for one cycle) on every transaction kind.
- R4: A strobe is the header alone, with chip select released right after it. Address 0 works as a status-only fetch.
- R5: A transmit-FIFO load sends the header and then `len` bytes from the owner's write stream, in order, with one wr_pop per byte. Each byte returned during the payload is presented as a fresh status byte.
- R6: A register read (REG_BYTES bytes) and a receive-FIFO read (`len` bytes) send 0x00 filler bytes. Each returned payload byte appears once on rd_data with rd_valid, and rd_port names the owner.
- R7: Chip select falls with the header and stays low through the last byte of the transaction. The block issues sh_go only while chip select is low.
- R8: A receive-FIFO read accepted while fifo_nempty is low is consumed without chip select falling. During such a read, no further payload byte is started once fifo_nempty is low.
- R9: When several requesters wait at once, the grant moves round-robin away from the last one served. At most one req_ready is high.
- R10: No req_ready is high while a transaction is in progress (chip select low).
- R11: Between two transactions, chip select stays high for at least GAP_CYCLES+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | NREQ | Per-requester start, held until accepted |
| req_op | input | 3*NREQ | Per-requester request kind code |
| req_addr | input | 6*NREQ | Per-requester register or command address |
| req_len | input | LEN_W*NREQ | Per-requester burst byte count |
| req_wdata | input | 8*NREQ | Per-requester head of write stream |
| req_ready | output | NREQ | Grant; start is taken on ready and start |
| wr_pop | output | NREQ | The current write byte was consumed |
| status_byte | output | 8 | Last captured radio status |
| status_valid | output | 1 | New status byte this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data valid this cycle |
| rd_port | output | PW | Owner of the current or last transaction |
| fifo_nempty | input | 1 | Radio receive FIFO holds data |
| cs_n | output | 1 | Active-low chip select to the radio |
| sh_go | output | 1 | Start shifting sh_tx |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shifter finished a byte |
| sh_rx | input | 8 | Byte shifted in |

## Verification
The assertions check on every cycle the rules that hold whatever the traffic. Chip select stays low while a byte is in flight, and no shift starts outside a frame. A receive-FIFO byte starts only when the FIFO reported data, and the high time between frames is met. Ready is never raised during a frame. A header completion is always followed by a status strobe, and the arbiter never re-grants the last winner while others wait. What only the bench scenarios can show is the content and count of each frame: exact header values, payload order from the write streams, where each returned byte is routed, early stop of a receive burst, refusal on an empty FIFO and the grant order under contention.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      OP_REG_WR = 3'd0,
      OP_REG_RD = 3'd1,
      OP_STROBE = 3'd2,
      OP_TXF_WR = 3'd3,
      OP_RXF_RD = 3'd4
   } seq_op_e;

   function automatic logic op_reads(seq_op_e op);
      return (op == OP_REG_RD) || (op == OP_RXF_RD);
   endfunction

   function automatic logic op_writes(seq_op_e op);
      return (op == OP_REG_WR) || (op == OP_TXF_WR);
   endfunction

   function automatic logic [7:0] frame_header(seq_op_e op, logic [5:0] addr);
      return {1'b0, op_reads(op), addr};
   endfunction

endpackage

// File: rtl/rsq_rr_arbiter.sv
module rsq_rr_arbiter #(
   parameter int N  = 2,
   parameter int IW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          advance,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] grant_idx
);

   if (N < 1) begin : g_bad_n
      $error("rsq_rr_arbiter: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign grant     = req;
      assign grant_idx = '0;
   end else begin : g_rotate
      logic [IW-1:0] last_q;
      logic [IW-1:0] cand;
      logic          found;

      always_comb begin
         grant     = '0;
         grant_idx = '0;
         found     = 1'b0;
         cand      = '0;
         for (int k = 1; k <= N; k++) begin
            cand = IW'((int'(last_q) + k) % N);
            if (!found && req[cand]) begin
               found       = 1'b1;
               grant_idx   = cand;
               grant[cand] = 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) last_q <= IW'(N - 1);
         else if (advance) last_q <= grant_idx;
      end

      // R9: with others waiting, the last winner is not served again
      p_rr_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (advance && ($countones(req) > 1)) |-> (grant_idx != last_q));
   end

endmodule

// File: rtl/rsq_frame_fsm.sv
module rsq_frame_fsm
   import rsq_pkg::*;
#(
   parameter int LEN_W      = 8,
   parameter int GAP_CYCLES = 3,
   parameter int REG_BYTES  = 2,
   parameter int PW         = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  seq_op_e          acc_op,
   input  logic [5:0]       acc_addr,
   input  logic [LEN_W-1:0] acc_len,
   input  logic [PW-1:0]    acc_port,
   input  logic [7:0]       own_wdata,
   input  logic             fifo_nempty,
   input  logic             sh_done,
   input  logic [7:0]       sh_rx,
   output logic             idle,
   output logic             cs_n,
   output logic             sh_go,
   output logic [7:0]       sh_tx,
   output logic             wpop,
   output logic [PW-1:0]    owner,
   output logic [7:0]       status_byte,
   output logic             status_valid,
   output logic [7:0]       rd_data,
   output logic             rd_valid
);

   localparam int GW    = $clog2(GAP_CYCLES + 1) + 1;
   localparam int HI_W  = $clog2(GAP_CYCLES + 2) + 1;
   localparam int HI_MAX = GAP_CYCLES + 1;

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("rsq_frame_fsm: GAP_CYCLES must be at least 1");
   end
   if (REG_BYTES < 1 || REG_BYTES >= (1 << LEN_W)) begin : g_bad_reg
      $error("rsq_frame_fsm: REG_BYTES must fit in LEN_W bits");
   end

   typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} fsm_e;

   fsm_e             state;
   seq_op_e          op_q;
   logic             hdr_q;
   logic [LEN_W-1:0] remain;
   logic [GW-1:0]    gap_cnt;
   logic             stop_now;

   function automatic logic [LEN_W-1:0] payload_len(seq_op_e op, logic [LEN_W-1:0] len);
      case (op)
         OP_REG_WR, OP_REG_RD: return LEN_W'(REG_BYTES);
         OP_TXF_WR, OP_RXF_RD: return len;
         default:              return '0;
      endcase
   endfunction

   assign idle     = (state == S_IDLE);
   assign stop_now = (remain == '0) || ((op_q == OP_RXF_RD) && !fifo_nempty);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         op_q         <= OP_STROBE;
         hdr_q        <= 1'b0;
         remain       <= '0;
         gap_cnt      <= '0;
         owner        <= '0;
         cs_n         <= 1'b1;
         sh_go        <= 1'b0;
         sh_tx        <= 8'h00;
         wpop         <= 1'b0;
         status_byte  <= 8'h00;
         status_valid <= 1'b0;
         rd_data      <= 8'h00;
         rd_valid     <= 1'b0;
      end else begin
         sh_go        <= 1'b0;
         wpop         <= 1'b0;
         status_valid <= 1'b0;
         rd_valid     <= 1'b0;
         case (state)
            S_IDLE: begin
               if (accept) begin
                  op_q  <= acc_op;
                  owner <= acc_port;
                  if (!((acc_op == OP_RXF_RD) && !fifo_nempty)) begin
                     cs_n   <= 1'b0;
                     sh_go  <= 1'b1;
                     sh_tx  <= frame_header(acc_op, acc_addr);
                     hdr_q  <= 1'b1;
                     remain <= payload_len(acc_op, acc_len);
                     state  <= S_SHIFT;
                  end
               end
            end
            S_SHIFT: begin
               if (sh_done) begin
                  hdr_q <= 1'b0;
                  if (hdr_q || (op_q == OP_TXF_WR)) begin
                     status_byte  <= sh_rx;
                     status_valid <= 1'b1;
                  end else if (op_reads(op_q)) begin
                     rd_data  <= sh_rx;
                     rd_valid <= 1'b1;
                  end
                  if (stop_now) begin
                     cs_n    <= 1'b1;
                     gap_cnt <= GW'(GAP_CYCLES - 1);
                     state   <= S_GAP;
                  end else begin
                     remain <= remain - 1'b1;
                     sh_go  <= 1'b1;
                     if (op_writes(op_q)) begin
                        sh_tx <= own_wdata;
                        wpop  <= 1'b1;
                     end else begin
                        sh_tx <= 8'h00;
                     end
                  end
               end
            end
            default: begin
               if (gap_cnt == '0) state <= S_IDLE;
               else gap_cnt <= gap_cnt - 1'b1;
            end
         endcase
      end
   end

   // Checker state: cycles chip select has been high, saturating
   logic [HI_W-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) hi_cnt <= HI_W'(HI_MAX);
      else if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != HI_W'(HI_MAX)) hi_cnt <= hi_cnt + 1'b1;
   end

   // R11: idle time between frames
   p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= HI_W'(HI_MAX)));
   // R7: frame held across every byte in flight
   p_cs_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SHIFT) |-> !cs_n);
   p_go_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sh_go |-> !cs_n);
   // R3: header completion always yields a status strobe
   p_hdr_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_SHIFT) && sh_done && hdr_q) |=> status_valid);
   // R4: a strobe frame ends after its header
   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_SHIFT) && sh_done && (op_q == OP_STROBE)) |=> cs_n);
   // R6: read data only from read kinds
   p_rd_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> op_reads(op_q));
   // R2: register write returns nothing on the data path
   p_regwr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_REG_WR) |-> !rd_valid);
   // R5: pops only accompany a written payload byte
   p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wpop |-> (sh_go && op_writes(op_q)));
   // R8: receive-FIFO bytes start only when the FIFO held data
   p_rxf_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_go && (op_q == OP_RXF_RD)) |-> $past(fifo_nempty));

endmodule

// File: rtl/radio_spi_sequencer.sv
module radio_spi_sequencer
   import rsq_pkg::*;
#(
   parameter int NREQ       = 2,
   parameter int LEN_W      = 8,
   parameter int GAP_CYCLES = 3,
   parameter int REG_BYTES  = 2,
   parameter int PW         = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NREQ-1:0]       req_start,
   input  logic [3*NREQ-1:0]     req_op,
   input  logic [6*NREQ-1:0]     req_addr,
   input  logic [LEN_W*NREQ-1:0] req_len,
   input  logic [8*NREQ-1:0]     req_wdata,
   output logic [NREQ-1:0]       req_ready,
   output logic [NREQ-1:0]       wr_pop,
   output logic [7:0]            status_byte,
   output logic                  status_valid,
   output logic [7:0]            rd_data,
   output logic                  rd_valid,
   output logic [PW-1:0]         rd_port,
   input  logic                  fifo_nempty,
   output logic                  cs_n,
   output logic                  sh_go,
   output logic [7:0]            sh_tx,
   input  logic                  sh_done,
   input  logic [7:0]            sh_rx
);

   if (NREQ < 1 || LEN_W < 1) begin : g_bad_top
      $error("radio_spi_sequencer: NREQ and LEN_W must be positive");
   end

   logic [NREQ-1:0] grant;
   logic [PW-1:0]   gidx;
   logic            idle;
   logic            accept;
   logic            wpop;
   logic [PW-1:0]   owner;
   logic [7:0]      own_wdata;

   rsq_rr_arbiter #(.N(NREQ), .IW(PW)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_start),
      .advance   (accept),
      .grant     (grant),
      .grant_idx (gidx)
   );

   assign req_ready = grant & {NREQ{idle}};
   assign accept    = |(req_start & req_ready);
   assign own_wdata = req_wdata[owner*8 +: 8];
   assign rd_port   = owner;

   for (genvar g = 0; g < NREQ; g++) begin : g_pop
      assign wr_pop[g] = wpop && (owner == PW'(g));
   end

   rsq_frame_fsm #(
      .LEN_W      (LEN_W),
      .GAP_CYCLES (GAP_CYCLES),
      .REG_BYTES  (REG_BYTES),
      .PW         (PW)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .acc_op       (seq_op_e'(req_op[gidx*3 +: 3])),
      .acc_addr     (req_addr[gidx*6 +: 6]),
      .acc_len      (req_len[gidx*LEN_W +: LEN_W]),
      .acc_port     (gidx),
      .own_wdata    (own_wdata),
      .fifo_nempty  (fifo_nempty),
      .sh_done      (sh_done),
      .sh_rx        (sh_rx),
      .idle         (idle),
      .cs_n         (cs_n),
      .sh_go        (sh_go),
      .sh_tx        (sh_tx),
      .wpop         (wpop),
      .owner        (owner),
      .status_byte  (status_byte),
      .status_valid (status_valid),
      .rd_data      (rd_data),
      .rd_valid     (rd_valid)
   );

   // R10: no grant while a frame is open
   p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_ready) |-> cs_n);
   // R9: single grant at a time
   p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

endmodule

// File: tb/tb_radio_spi_sequencer.sv
module tb_radio_spi_sequencer;
   import rsq_pkg::*;

   localparam int GAP = 3;
   localparam int LAT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       start_v [2];
   logic [2:0] op_v    [2];
   logic [5:0] addr_v  [2];
   logic [7:0] len_v   [2];
   logic [7:0] wbuf    [2][16];
   logic [3:0] widx    [2];
   logic [3:0] pw      [2];

   logic [1:0]  req_ready, wr_pop;
   logic [7:0]  status_byte, rd_data, sh_tx, sh_rx;
   logic        status_valid, rd_valid, cs_n, sh_go, sh_done, fifo_nempty;
   logic [0:0]  rd_port;

   int rxf_taken = 0;
   int rxf_limit = 0;
   assign fifo_nempty = (rxf_taken < rxf_limit);

   radio_spi_sequencer #(.NREQ(2), .LEN_W(8), .GAP_CYCLES(GAP), .REG_BYTES(2)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_start({start_v[1], start_v[0]}),
      .req_op({op_v[1], op_v[0]}),
      .req_addr({addr_v[1], addr_v[0]}),
      .req_len({len_v[1], len_v[0]}),
      .req_wdata({wbuf[1][widx[1]], wbuf[0][widx[0]]}),
      .req_ready(req_ready), .wr_pop(wr_pop),
      .status_byte(status_byte), .status_valid(status_valid),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_port(rd_port),
      .fifo_nempty(fifo_nempty),
      .cs_n(cs_n), .sh_go(sh_go), .sh_tx(sh_tx),
      .sh_done(sh_done), .sh_rx(sh_rx)
   );

   function automatic logic [7:0] resp(int i);
      return 8'h40 ^ 8'(i * 37);
   endfunction

   // Byte shifter and radio model
   int  m_idx = 0;
   int  m_cnt = 0;
   logic m_busy = 1'b0, frame_open = 1'b0, frame_rxf = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         sh_done <= 1'b0; sh_rx <= 8'h00; m_busy <= 1'b0;
      end else begin
         sh_done <= 1'b0;
         if (m_busy) begin
            if (m_cnt == 0) begin
               sh_done <= 1'b1; sh_rx <= resp(m_idx); m_idx <= m_idx + 1; m_busy <= 1'b0;
            end else m_cnt <= m_cnt - 1;
         end
         if (sh_go) begin
            m_busy <= 1'b1; m_cnt <= LAT;
            if (!frame_open) begin
               frame_open <= 1'b1; frame_rxf <= (sh_tx == 8'h7F);
            end else if (frame_rxf) rxf_taken <= rxf_taken + 1;
         end else if (cs_n) frame_open <= 1'b0;
      end
   end

   // Scoreboard
   int nchk = 0, nfail = 0;
   logic [7:0] exp_tx[$];
   logic [7:0] exp_st[$];
   logic [8:0] exp_rd[$];
   int pred = 0;
   int n_go = 0, n_fall = 0, hi_run = 1000, bad_ready = 0, bad_go = 0;
   logic cs_prev = 1'b1;

   task automatic chk(bit ok, string tag, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (sh_go) begin
            n_go++;
            if (cs_n) bad_go++;
            if (exp_tx.size() == 0) chk(0, "R1 unexpected byte on wire", sh_tx, 0);
            else begin
               logic [7:0] e; e = exp_tx.pop_front();
               chk(sh_tx == e, "R1/R5 wire byte", sh_tx, e);
            end
         end
         if (status_valid) begin
            if (exp_st.size() == 0) chk(0, "R3 unexpected status", status_byte, 0);
            else begin
               logic [7:0] e; e = exp_st.pop_front();
               chk(status_byte == e, "R3 status byte", status_byte, e);
            end
         end
         if (rd_valid) begin
            if (exp_rd.size() == 0) chk(0, "R2/R6 unexpected read data", rd_data, 0);
            else begin
               logic [8:0] e; e = exp_rd.pop_front();
               chk({rd_port, rd_data} == e, "R6 read data and port", {rd_port, rd_data}, e);
            end
         end
         for (int p = 0; p < 2; p++) if (wr_pop[p]) widx[p] = widx[p] + 1'b1;
         if (!cs_n && (|req_ready)) bad_ready++;
         if (!cs_n && cs_prev) begin
            n_fall++;
            chk(hi_run >= GAP + 1, "R11 chip select high time", hi_run, GAP + 1);
         end
         hi_run  = cs_n ? hi_run + 1 : 0;
         cs_prev = cs_n;
      end
   end

   task automatic expect_txn(int p, seq_op_e op, logic [5:0] a, int npay);
      logic rd;
      rd = (op == OP_REG_RD) || (op == OP_RXF_RD);
      exp_tx.push_back({1'b0, rd, a});
      exp_st.push_back(resp(pred)); pred++;
      for (int i = 0; i < npay; i++) begin
         if (op == OP_REG_WR || op == OP_TXF_WR) begin
            exp_tx.push_back(wbuf[p][pw[p]]); pw[p] = pw[p] + 1'b1;
         end else exp_tx.push_back(8'h00);
         if (op == OP_TXF_WR) exp_st.push_back(resp(pred));
         else if (rd) exp_rd.push_back({p[0], resp(pred)});
         pred++;
      end
   endtask

   task automatic issue(int p, seq_op_e op, logic [5:0] a, logic [7:0] n);
      @(negedge clk);
      start_v[p] = 1'b1; op_v[p] = op; addr_v[p] = a; len_v[p] = n;
      #1;
      while (!req_ready[p]) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      start_v[p] = 1'b0;
   endtask

   task automatic wait_quiet();
      do @(negedge clk);
      while (exp_tx.size() != 0 || exp_st.size() != 0 || exp_rd.size() != 0 || !cs_n);
      repeat (GAP + 3) @(negedge clk);
   endtask

   task automatic finish_test();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_test();
   end

   initial begin
      int f0, g0;
      for (int p = 0; p < 2; p++) begin
         start_v[p] = 0; op_v[p] = 0; addr_v[p] = 0; len_v[p] = 0; widx[p] = 0; pw[p] = 0;
         for (int i = 0; i < 16; i++) wbuf[p][i] = 8'(8'hC0 + 16 * p + i);
      end
      wbuf[0][0] = 8'h12; wbuf[0][1] = 8'h34;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(cs_n == 1'b1, "reset cs_n", cs_n, 1);
      chk(sh_go == 1'b0 && status_valid == 1'b0 && rd_valid == 1'b0, "reset strobes",
          {sh_go, status_valid, rd_valid}, 0);
      chk(req_ready == 2'b00, "R9 reset ready without start", req_ready, 0);

      // R2: register write, header 0x15, data 12 34, nothing on read path
      f0 = n_fall;
      expect_txn(0, OP_REG_WR, 6'h15, 2);
      issue(0, OP_REG_WR, 6'h15, 8'd9);
      wait_quiet();
      chk(n_fall == f0 + 1, "R7 register write in one frame", n_fall - f0, 1);

      // R6: register read from port 1, header 0x50
      expect_txn(1, OP_REG_RD, 6'h10, 2);
      issue(1, OP_REG_RD, 6'h10, 8'd0);
      wait_quiet();

      // R4: status-only strobe at address 0, then another strobe
      g0 = n_go;
      expect_txn(0, OP_STROBE, 6'h00, 0);
      issue(0, OP_STROBE, 6'h00, 8'd5);
      wait_quiet();
      chk(n_go == g0 + 1, "R4 strobe is one byte", n_go - g0, 1);
      expect_txn(1, OP_STROBE, 6'h08, 0);
      issue(1, OP_STROBE, 6'h08, 8'd0);
      wait_quiet();

      // R5: transmit-FIFO load of 4 bytes, one frame
      f0 = n_fall;
      expect_txn(0, OP_TXF_WR, 6'h3E, 4);
      issue(0, OP_TXF_WR, 6'h3E, 8'd4);
      wait_quiet();
      chk(n_fall == f0 + 1, "R7 burst held in one frame", n_fall - f0, 1);
      chk(widx[0] == pw[0], "R5 pop count", widx[0], pw[0]);
      // R5: zero-length load is header only
      g0 = n_go;
      expect_txn(0, OP_TXF_WR, 6'h3E, 0);
      issue(0, OP_TXF_WR, 6'h3E, 8'd0);
      wait_quiet();
      chk(n_go == g0 + 1, "R5 zero-length load", n_go - g0, 1);

      // R6: receive-FIFO read of 3 with 5 available
      @(negedge clk); rxf_limit = rxf_taken + 5;
      expect_txn(1, OP_RXF_RD, 6'h3F, 3);
      issue(1, OP_RXF_RD, 6'h3F, 8'd3);
      wait_quiet();
      // R8: request 5, only 2 available: stops after 2
      @(negedge clk); rxf_limit = rxf_taken + 2;
      g0 = n_go;
      expect_txn(1, OP_RXF_RD, 6'h3F, 2);
      issue(1, OP_RXF_RD, 6'h3F, 8'd5);
      wait_quiet();
      chk(n_go == g0 + 3, "R8 early stop byte count", n_go - g0, 3);
      // R8: empty FIFO refuses the read
      g0 = n_go; f0 = n_fall;
      issue(1, OP_RXF_RD, 6'h3F, 8'd3);
      repeat (20) @(negedge clk);
      chk(n_go == g0 && n_fall == f0, "R8 refused read left chip select high", n_go - g0, 0);

      // R9: contention, expected grant order 0,1,0,1
      expect_txn(0, OP_STROBE, 6'h01, 0);
      expect_txn(1, OP_STROBE, 6'h03, 0);
      expect_txn(0, OP_STROBE, 6'h02, 0);
      expect_txn(1, OP_STROBE, 6'h04, 0);
      fork
         begin issue(0, OP_STROBE, 6'h01, 8'd0); issue(0, OP_STROBE, 6'h02, 8'd0); end
         begin issue(1, OP_STROBE, 6'h03, 8'd0); issue(1, OP_STROBE, 6'h04, 8'd0); end
      join
      wait_quiet();

      chk(bad_ready == 0, "R10 ready during frame", bad_ready, 0);
      chk(bad_go == 0, "R7 shift outside frame", bad_go, 0);
      chk(exp_tx.size() == 0 && exp_st.size() == 0 && exp_rd.size() == 0,
          "R3 scoreboard drained", exp_tx.size() + exp_st.size() + exp_rd.size(), 0);
      finish_test();
   end

endmodule